// File: doc/BRIEF.md
# Fractional SCL Tick Divider

This block derives the half-period timing strobe for a two-wire serial bus master from the module input clock. On each active step it adds a programmed increment to a phase accumulator. When the sum reaches the programmed modulus it subtracts the modulus and raises a single-cycle strobe. With an increment of one and a modulus equal to the input clock divided by twice the bus clock, the strobe arrives twice per bus period, once for each half of the serial clock. A non-unit increment gives fractional ratios.

Two configuration words with the same layout are held: one for the standard rate and one for the high-speed rate. A mode input chooses between them. An 8-bit prescaler sets how many input clocks make one accumulator step, and a prescaler value of zero halts the block. All configuration is accepted only while the block is stopped. A selected setting that is not usable raises an error flag and silences the strobe.

Top module: `frac_scl_divider`

## Requirements
- R1: After synchronous reset both configuration words are zero, the prescaler value is 1, `scl_tick` is 0 and `cfg_err` is 1, because the zero configuration is invalid.
- R2: A configuration word carries the modulus in bits [FIELD_W-1:0] and the increment in bits [16+FIELD_W-1:16]. `cfg_sel` = 0 writes the standard-rate word and `cfg_sel` = 1 writes the high-speed word.
- R3: Writes to either configuration word or to the prescaler take effect only when `run_en` is 0 at the clock edge. A write made while `run_en` is 1 is discarded.
- R4: Counting steps from 1 after a restart, the edge of step k raises `scl_tick` for exactly one cycle if and only if floor(k*inc/dec) > floor((k-1)*inc/dec). With inc = dec, every step ticks.
- R5: A restart occurs on the first edge at which `run_en` is 1 after being 0. It also occurs on any edge at which `run_en` is 1 and `hs_mode` differs from its value at the previous edge. A restart clears the accumulator and the prescaler, and it produces no tick.
- R6: The configuration in use is the high-speed word when `hs_mode` was 1 at the previous edge, and the standard-rate word otherwise.
- R7: The selected setting is invalid when its modulus is below 7, its increment is 0, or its increment exceeds its modulus. While it is invalid, `cfg_err` is 1 and `scl_tick` stays 0. A modulus of exactly 7 with a nonzero increment no larger than the modulus is valid.
- R8: With prescaler value N (8 bits), accumulator step k falls on edge k*N after the restart. N = 0 produces no ticks.
- R9: While `run_en` is 0 the accumulator is held at zero and `scl_tick` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module input clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; configuration is locked while high |
| hs_mode | input | 1 | Selects the high-speed configuration word |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 1 | Target word: 0 standard, 1 high-speed |
| cfg_wdata | input | 32 | Configuration word (increment high, modulus low) |
| div_we | input | 1 | Prescaler write strobe |
| div_wdata | input | 8 | Prescaler value; 0 halts the block |
| scl_tick | output | 1 | One-cycle half-period strobe |
| cfg_err | output | 1 | Selected configuration is invalid |

## Verification
A mode change while running can fall on the same edge where the accumulator would otherwise have wrapped. The bench switches `hs_mode` one edge before the high-speed setting's next tick and expects the restart to win, so no strobe appears on that edge. Counting then resumes from step 1 under the standard word. A second coincidence is a configuration and prescaler write landing on an edge where the divider is running. The monitor requires the tick sequence to continue unchanged, both during that run and on the run that follows it.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int CFG_W   = 32;
  localparam int INC_LSB = 16;
  localparam int MIN_DEC = 7;

  typedef enum logic {
    BANK_STD = 1'b0,
    BANK_HS  = 1'b1
  } bank_e;
endpackage

// File: rtl/fdiv_cfg_bank.sv
module fdiv_cfg_bank
  import fdiv_pkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               div_we,
  input  logic [DIV_W-1:0]   div_wdata,
  input  logic               hs_q,
  output logic [FIELD_W-1:0] inc_use,
  output logic [FIELD_W-1:0] dec_use,
  output logic [DIV_W-1:0]   div_use,
  output logic               cfg_bad
);
  localparam int NBANK = 2;

  logic [FIELD_W-1:0] inc_r [NBANK];
  logic [FIELD_W-1:0] dec_r [NBANK];
  logic [DIV_W-1:0]   div_r;

  // configuration is writable only while stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANK; b++) begin
        inc_r[b] <= '0;
        dec_r[b] <= '0;
      end
    end else if (cfg_we && !run_en) begin
      for (int b = 0; b < NBANK; b++) begin
        if (cfg_sel == b[0]) begin
          inc_r[b] <= cfg_wdata[INC_LSB +: FIELD_W];
          dec_r[b] <= cfg_wdata[FIELD_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    div_r <= DIV_W'(1);
    else if (div_we && !run_en) div_r <= div_wdata;
  end

  always_comb begin
    if (bank_e'(hs_q) == BANK_HS) begin
      inc_use = inc_r[1];
      dec_use = dec_r[1];
    end else begin
      inc_use = inc_r[0];
      dec_use = dec_r[0];
    end
  end

  assign div_use = div_r;
  assign cfg_bad = (dec_use < FIELD_W'(MIN_DEC)) || (inc_use == '0) || (inc_use > dec_use);

  // R3: stored configuration cannot move while running
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    $past(run_en) |-> ($stable(inc_r[0]) && $stable(dec_r[0]) &&
                       $stable(inc_r[1]) && $stable(dec_r[1]) && $stable(div_r)));
endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_use,
  output logic             step
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (div_use != '0) && (cnt == div_use - DIV_W'(1));
  assign step = active && !restart && wrap;

  always_ff @(posedge clk) begin
    if (rst || !active || restart) cnt <= '0;
    else if (div_use != '0)        cnt <= wrap ? '0 : cnt + DIV_W'(1);
  end

  // R8: phase counter stays inside the prescaler period
  p_cnt_in_period_r8: assert property (@(posedge clk) disable iff (rst)
    (div_use != '0) |-> (cnt < div_use));
endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
  parameter int FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic               restart,
  input  logic               step,
  input  logic               cfg_bad,
  input  logic [FIELD_W-1:0] inc_use,
  input  logic [FIELD_W-1:0] dec_use,
  output logic               tick
);
  logic [FIELD_W-1:0] acc;
  logic [FIELD_W:0]   sum;
  logic [FIELD_W:0]   rem;
  logic               hit;

  assign sum = {1'b0, acc} + {1'b0, inc_use};
  assign hit = (sum >= {1'b0, dec_use});
  assign rem = sum - {1'b0, dec_use};

  always_ff @(posedge clk) begin
    if (rst || !active || restart || cfg_bad) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (step) begin
      tick <= hit;
      acc  <= hit ? rem[FIELD_W-1:0] : sum[FIELD_W-1:0];
    end else begin
      tick <= 1'b0;
    end
  end

  // R4: residue stays below the modulus of a valid setting
  p_acc_below_dec_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_bad |-> (acc < dec_use));
  // R4: a tick always comes from a prescaler step
  p_tick_from_step_r4: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(step));
  // R7: no tick follows an invalid setting
  p_quiet_when_bad_r7: assert property (@(posedge clk) disable iff (rst)
    tick |-> !$past(cfg_bad));
endmodule

// File: rtl/frac_scl_divider.sv
module frac_scl_divider
  import fdiv_pkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             hs_mode,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             scl_tick,
  output logic             cfg_err
);
  logic               run_q;
  logic               hs_q;
  logic               restart;
  logic               step;
  logic               bad;
  logic [FIELD_W-1:0] inc_use;
  logic [FIELD_W-1:0] dec_use;
  logic [DIV_W-1:0]   div_use;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      hs_q  <= 1'b0;
    end else begin
      run_q <= run_en;
      hs_q  <= hs_mode;
    end
  end

  assign restart = run_en && (!run_q || (hs_mode != hs_q));

  fdiv_cfg_bank #(.FIELD_W(FIELD_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst(rst), .run_en(run_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .hs_q(hs_q),
    .inc_use(inc_use), .dec_use(dec_use), .div_use(div_use), .cfg_bad(bad)
  );

  fdiv_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .active(run_en), .restart(restart),
    .div_use(div_use), .step(step)
  );

  fdiv_accum #(.FIELD_W(FIELD_W)) u_acc (
    .clk(clk), .rst(rst), .active(run_en), .restart(restart), .step(step),
    .cfg_bad(bad), .inc_use(inc_use), .dec_use(dec_use), .tick(scl_tick)
  );

  assign cfg_err = bad;

  // R9: silent while stopped
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !scl_tick);
  // R5: restart edge never ticks
  p_restart_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> !scl_tick);
endmodule

// File: tb/frac_scl_divider_test.sv
module frac_scl_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0, hs_mode = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        div_we = 1'b0;
  logic [7:0]  div_wdata = '0;
  logic        scl_tick, cfg_err;

  int    n_checks = 0, n_fail = 0;
  string cur_tag = "R4";
  bit    exp_q[$];
  bit    done = 1'b0;

  always #5 clk = ~clk;

  frac_scl_divider uut (
    .clk(clk), .rst(rst), .run_en(run_en), .hs_mode(hs_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .scl_tick(scl_tick), .cfg_err(cfg_err)
  );

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_tick(longint e, longint inc, longint dec, longint n);
    longint k;
    if (n == 0 || (e % n) != 0) return 1'b0;
    k = e / n;
    return ((k * inc) / dec) != (((k - 1) * inc) / dec);
  endfunction

  // monitor: pops one expectation per cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      check(cur_tag, scl_tick, e);
    end
  end

  // all tasks start and end at a falling edge
  task automatic write_cfg(bit sel, int inc, int dec);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = {inc[15:0], dec[15:0]};
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_div(int n);
    div_we = 1'b1; div_wdata = n[7:0];
    @(negedge clk);
    div_we = 1'b0;
    @(negedge clk);
  endtask

  // a restart-causing input change was made at this falling edge
  task automatic count_run(int inc, int dec, int n, int cycles, int poke);
    @(posedge clk);
    exp_q.push_back(1'b0);
    for (int e = 1; e <= cycles; e++) begin
      @(posedge clk);
      exp_q.push_back(exp_tick(e, inc, dec, n));
      if (e == poke) begin
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = {16'd1, 16'd7};
        div_we = 1'b1; div_wdata = 8'd1;
      end
      if (e == poke + 1) begin
        @(negedge clk);
        cfg_we = 1'b0; div_we = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic start_run(int inc, int dec, int n, int cycles, int poke);
    run_en = 1'b1;
    count_run(inc, dec, n, cycles, poke);
  endtask

  task automatic stop_run();
    run_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9", scl_tick, 1'b0);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", scl_tick, 1'b0);
    check("R1", cfg_err, 1'b1);

    // R2: field layout, integer ratio
    write_cfg(1'b0, 1, 10);
    check("R2", cfg_err, 1'b0);
    cur_tag = "R2";
    start_run(1, 10, 1, 45, 0);
    stop_run();

    // R4: fractional ratio
    write_cfg(1'b0, 3, 7);
    cur_tag = "R4";
    start_run(3, 7, 1, 40, 0);
    stop_run();

    // R8: prescaler of 3
    write_cfg(1'b0, 2, 9);
    write_div(3);
    cur_tag = "R8";
    start_run(2, 9, 3, 40, 0);
    stop_run();

    // R6: high-speed word selected by mode
    write_cfg(1'b1, 1, 8);
    hs_mode = 1'b1;
    @(negedge clk);
    check("R6", cfg_err, 1'b0);
    cur_tag = "R6";
    start_run(1, 8, 3, 23, 0);
    // R5: mode flip one edge before a tick; restart wins
    hs_mode = 1'b0;
    cur_tag = "R5";
    count_run(2, 9, 3, 30, 0);
    stop_run();

    // R3: writes while running are discarded
    cur_tag = "R3";
    start_run(2, 9, 3, 30, 10);
    stop_run();
    start_run(2, 9, 3, 15, 0);
    stop_run();

    // R7: invalid settings
    write_cfg(1'b0, 1, 6);
    check("R7", cfg_err, 1'b1);
    cur_tag = "R7";
    start_run(1, 6, 0, 20, 0);
    stop_run();
    write_cfg(1'b0, 0, 7);
    check("R7", cfg_err, 1'b1);
    write_cfg(1'b0, 8, 7);
    check("R7", cfg_err, 1'b1);
    write_cfg(1'b0, 1, 7);
    check("R7", cfg_err, 1'b0);

    // R8: prescaler zero halts
    write_div(0);
    cur_tag = "R8";
    start_run(1, 7, 0, 20, 0);
    stop_run();

    // R4: increment equals modulus ticks every step
    write_div(1);
    write_cfg(1'b0, 7, 7);
    cur_tag = "R4";
    start_run(7, 7, 1, 12, 0);
    stop_run();

    done = 1'b1;
    finish_up();
  end
endmodule